// File: doc/BRIEF.md
# Status Context Save Stack

This block keeps a small last-in, first-out store of processor context. Each entry holds two words taken together: the arithmetic status word and the mode control word. Entries are saved when software issues an explicit save strobe, or when the core begins servicing one of the three external request lines or the timer. Servicing any other interrupt source saves nothing. An explicit restore strobe removes the newest entry. A return from interrupt removes it only when the matching interrupt entry saved one. A one-bit record per nesting level remembers which interrupt entries saved.

Every save also returns a write-back value for the live mode word. In that value, each bit selected by a software-written mode-clear mask is forced to zero, so chosen modes are turned off while a handler runs. A restore returns both saved words combinationally in the cycle the strobe is presented, for the core to load. Full and empty flags and sticky overflow and underflow exceptions report misuse of the stack.

Top module: `ctx_status_stack`

## Requirements
- R1: While the stack is not empty, a restore (pop_req, or a qualifying irq_return) raises stat_wr_en and mode_wr_en in the same cycle, with stat_wr_data and mode_wr_data equal to the two words of the newest entry. Those are the status_in and mode_in values that were present at the save that created the entry.
- R2: A save happens on push_req, or on irq_entry when irq_src is 0, 1 or 2 (external request lines) or 3 (timer). After a save into an empty stack, stk_empty is 0.
- R3: irq_entry with irq_src from 4 to 7 saves nothing. mode_wr_en stays 0 and the stack depth is unchanged.
- R4: On every save, mode_wr_en is 1 in the same cycle, and mode_wr_data equals mode_in with every bit cleared whose bit in the mode-clear mask is 1. The mask is loaded from mmask_wdata when mmask_we is 1 and takes effect from the next cycle.
- R5: irq_return restores only if the interrupt entry at the current nesting level saved. Otherwise stat_wr_en stays 0, the depth is unchanged and no underflow is raised. Nesting levels unwind in reverse order of entry.
- R6: Entries come back in reverse order of saving. The stack holds 15 entries, and stk_full is 1 exactly when 15 entries are held.
- R7: A save into a full stack, without a restore in the same cycle, sets ovf_err. The flag stays set until reset, and no stored entry changes.
- R8: A restore on an empty stack sets ovf's counterpart unf_err, which stays set until reset. stat_wr_en stays 0, and mode_wr_en stays 0 unless a save happens in the same cycle.
- R9: A save and a restore in the same cycle act as the restore first, then the save. The newest entry is returned on the write-back outputs, and mode_wr_data is that entry's mode word with the masked bits cleared. The current inputs replace it as the newest entry, so the depth is unchanged and no overflow is raised even when the stack is full.
- R10: After reset, stk_empty is 1, stk_full, ovf_err and unf_err are 0, and the mode-clear mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Explicit save strobe |
| pop_req | input | 1 | Explicit restore strobe |
| irq_entry | input | 1 | Start of interrupt service strobe |
| irq_src | input | 3 | Source tag of the interrupt being entered |
| irq_return | input | 1 | Return-from-interrupt strobe |
| status_in | input | 32 | Live arithmetic status word |
| mode_in | input | 32 | Live mode control word |
| mmask_we | input | 1 | Mode-clear mask write enable |
| mmask_wdata | input | 32 | Mode-clear mask write data |
| stat_wr_en | output | 1 | Load restored status word |
| stat_wr_data | output | 32 | Restored status word |
| mode_wr_en | output | 1 | Load mode word |
| mode_wr_data | output | 32 | Mode word to load (restored, or cleared on save) |
| stk_full | output | 1 | Stack holds 15 entries |
| stk_empty | output | 1 | Stack holds no entry |
| ovf_err | output | 1 | Sticky overflow exception |
| unf_err | output | 1 | Sticky underflow exception |

## Verification
Saves are made with every tag, from 0 to 3 and from 4 up. This separates the sources that save from those that must not. Mixed nesting of explicit saves, saving interrupts and non-saving interrupts shows whether each return unwinds only what its own entry saved. Filling the stack to depth 15 and overfilling it shows the order of entries and that they stay intact. Same-cycle save and restore is tried on a full and on an empty stack, which tells the restore-first ordering apart from a plain save or an overflow.

// File: rtl/ctx_stack_pkg.sv
// Shared widths and types for the status context stack.
// Assumes status and mode words have fixed widths across the core.
package ctx_stack_pkg;
    parameter int unsigned CTX_STAT_W = 32;
    parameter int unsigned CTX_MODE_W = 32;

    typedef struct packed {
        logic [CTX_STAT_W-1:0] stat;
        logic [CTX_MODE_W-1:0] mode;
    } ctx_entry_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stk_op_e;
endpackage

// File: rtl/ctx_entry_store.sv
// Entry storage with occupancy count and sticky error flags.
// Performs one resolved operation per cycle: push, pop, or swap (pop then push).
// Assumes the caller has already merged every request into a single op.
module ctx_entry_store
    import ctx_stack_pkg::*;
#(
    parameter int unsigned DEPTH = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  stk_op_e    op,
    input  ctx_entry_t wr_entry,
    output ctx_entry_t top_entry,
    output logic       pop_ok,
    output logic       full,
    output logic       empty,
    output logic       ovf,
    output logic       unf
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ctx_entry_t       mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_cnt;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             pop_kind;

    // Decode occupancy and the read and write positions.
    always_comb begin
        empty    = (cnt_q == '0);
        full     = (cnt_q == CNT_W'(DEPTH));
        top_cnt  = empty ? '0 : cnt_q - CNT_W'(1);
        rd_idx   = top_cnt[IDX_W-1:0];
        wr_idx   = cnt_q[IDX_W-1:0];
        pop_kind = (op == OP_POP) || (op == OP_SWAP);
        pop_ok   = pop_kind && !empty;
        top_entry = empty ? '0 : mem[rd_idx];
    end

    // Update the count and the sticky exception flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            case (op)
                OP_PUSH: begin
                    if (full) ovf   <= 1'b1;
                    else      cnt_q <= cnt_q + CNT_W'(1);
                end
                OP_POP: begin
                    if (empty) unf   <= 1'b1;
                    else       cnt_q <= cnt_q - CNT_W'(1);
                end
                OP_SWAP: begin
                    if (empty) begin
                        unf   <= 1'b1;
                        cnt_q <= CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Write entry contents; storage itself carries no reset.
    always_ff @(posedge clk) begin
        if (op == OP_PUSH && !full) begin
            mem[wr_idx] <= wr_entry;
        end else if (op == OP_SWAP) begin
            mem[rd_idx] <= wr_entry;
        end
    end
endmodule

// File: rtl/ctx_nest_tracker.sv
// Per-nesting-level record of whether an interrupt entry saved context.
// Bit 0 is the innermost level. Assumes nesting deeper than NEST_DEPTH
// never happens, since the oldest record is dropped when it does.
module ctx_nest_tracker #(
    parameter int unsigned NEST_DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic leave,
    input  logic enter_saved,
    output logic cur_saved
);
    logic [NEST_DEPTH-1:0] flags_q;

    // Report the record of the innermost active level.
    always_comb cur_saved = flags_q[0];

    // Shift records in on entry and out on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            case ({enter, leave})
                2'b10: flags_q <= {flags_q[NEST_DEPTH-2:0], enter_saved};
                2'b01: flags_q <= {1'b0, flags_q[NEST_DEPTH-1:1]};
                2'b11: flags_q[0] <= enter_saved;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctx_mode_mask.sv
// Mode-clear mask register and the masking of a mode word.
// A mask write takes effect from the following cycle.
module ctx_mode_mask
    import ctx_stack_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CTX_MODE_W-1:0] wdata,
    input  logic [CTX_MODE_W-1:0] mode_base,
    output logic [CTX_MODE_W-1:0] mode_cleared
);
    logic [CTX_MODE_W-1:0] mask_q;

    // Hold the software-written mask.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask_q <= '0;
        else if (we) mask_q <= wdata;
    end

    // Clear every selected mode bit.
    always_comb mode_cleared = mode_base & ~mask_q;
endmodule

// File: rtl/ctx_status_stack.sv
// Status context stack top: merges save and restore requests into one op,
// qualifies interrupt returns by the nesting record, and produces the
// write-back values for the live status and mode words.
// Assumes at most one interrupt entry and one return per cycle.
module ctx_status_stack
    import ctx_stack_pkg::*;
#(
    parameter int unsigned DEPTH        = 15,
    parameter int unsigned NEST_DEPTH   = 8,
    parameter int unsigned SRC_W        = 3,
    parameter int unsigned PUSH_SRC_MAX = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_req,
    input  logic                  pop_req,
    input  logic                  irq_entry,
    input  logic [SRC_W-1:0]      irq_src,
    input  logic                  irq_return,
    input  logic [CTX_STAT_W-1:0] status_in,
    input  logic [CTX_MODE_W-1:0] mode_in,
    input  logic                  mmask_we,
    input  logic [CTX_MODE_W-1:0] mmask_wdata,
    output logic                  stat_wr_en,
    output logic [CTX_STAT_W-1:0] stat_wr_data,
    output logic                  mode_wr_en,
    output logic [CTX_MODE_W-1:0] mode_wr_data,
    output logic                  stk_full,
    output logic                  stk_empty,
    output logic                  ovf_err,
    output logic                  unf_err
);
    logic                  src_saves;
    logic                  cur_saved;
    logic                  push_do;
    logic                  pop_do;
    stk_op_e               op;
    ctx_entry_t            wr_entry;
    ctx_entry_t            top_entry;
    logic                  pop_ok;
    logic [CTX_MODE_W-1:0] mode_base;
    logic [CTX_MODE_W-1:0] mode_cleared;

    // Merge the request strobes into one stack operation.
    always_comb begin
        src_saves = (irq_src <= SRC_W'(PUSH_SRC_MAX));
        push_do   = push_req || (irq_entry && src_saves);
        pop_do    = pop_req  || (irq_return && cur_saved);
        case ({push_do, pop_do})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_NONE;
        endcase
        wr_entry.stat = status_in;
        wr_entry.mode = mode_in;
    end

    ctx_nest_tracker #(
        .NEST_DEPTH (NEST_DEPTH)
    ) i_nest (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter       (irq_entry),
        .leave       (irq_return),
        .enter_saved (src_saves),
        .cur_saved   (cur_saved)
    );

    ctx_entry_store #(
        .DEPTH (DEPTH)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .wr_entry  (wr_entry),
        .top_entry (top_entry),
        .pop_ok    (pop_ok),
        .full      (stk_full),
        .empty     (stk_empty),
        .ovf       (ovf_err),
        .unf       (unf_err)
    );

    // Restore first, then clear masked bits of the resulting mode on a save.
    always_comb mode_base = pop_ok ? top_entry.mode : mode_in;

    ctx_mode_mask i_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (mmask_we),
        .wdata        (mmask_wdata),
        .mode_base    (mode_base),
        .mode_cleared (mode_cleared)
    );

    // Drive the write-back ports for the live registers.
    always_comb begin
        stat_wr_en   = pop_ok;
        stat_wr_data = top_entry.stat;
        mode_wr_en   = pop_ok || push_do;
        mode_wr_data = push_do ? mode_cleared : top_entry.mode;
    end
endmodule

// File: rtl/ctx_status_stack_chk.sv
// Property checker for the status context stack, bound to every instance.
module ctx_status_stack_chk
    import ctx_stack_pkg::*;
#(
    parameter int unsigned SRC_W        = 3,
    parameter int unsigned PUSH_SRC_MAX = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_req,
    input logic             pop_req,
    input logic             irq_entry,
    input logic [SRC_W-1:0] irq_src,
    input logic             irq_return,
    input logic             stat_wr_en,
    input logic             mode_wr_en,
    input logic             stk_full,
    input logic             stk_empty,
    input logic             ovf_err,
    input logic             unf_err
);
    // R6
    full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_full && stk_empty));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |=> unf_err);

    // R8
    empty_no_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_empty |-> !stat_wr_en);

    // R1
    pop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !stk_empty) |-> (stat_wr_en && mode_wr_en));

    // R4
    push_mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> mode_wr_en);

    // R7
    full_push_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_full && push_req && !pop_req && !irq_return) |=> ovf_err);

    // R3
    other_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_entry && (irq_src > SRC_W'(PUSH_SRC_MAX)) && !push_req && !pop_req && !irq_return)
        |-> !mode_wr_en);

    // R9
    swap_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !stk_empty) |=> (!stk_empty && $stable(stk_full)));
endmodule

bind ctx_status_stack ctx_status_stack_chk #(
    .SRC_W        (SRC_W),
    .PUSH_SRC_MAX (PUSH_SRC_MAX)
) i_chk (.*);

// File: tb/test_ctx_status_stack.sv
// Directed bench: one task per scenario, each checking its own results.
module test_ctx_status_stack;
    localparam logic [31:0] MSK = 32'h0000_F00F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 0, pop_req = 0, irq_entry = 0, irq_return = 0, mmask_we = 0;
    logic [2:0]  irq_src = '0;
    logic [31:0] status_in = '0, mode_in = '0, mmask_wdata = '0;
    logic        stat_wr_en, mode_wr_en, stk_full, stk_empty, ovf_err, unf_err;
    logic [31:0] stat_wr_data, mode_wr_data;

    logic        c_swe, c_mwe;
    logic [31:0] c_swd, c_mwd;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ctx_status_stack i_ctx_status_stack (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .irq_entry(irq_entry), .irq_src(irq_src), .irq_return(irq_return),
        .status_in(status_in), .mode_in(mode_in), .mmask_we(mmask_we),
        .mmask_wdata(mmask_wdata), .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data), .stk_full(stk_full),
        .stk_empty(stk_empty), .ovf_err(ovf_err), .unf_err(unf_err)
    );

    function automatic logic [31:0] st(input int i);
        return 32'hA000_0000 + 32'(i);
    endfunction
    function automatic logic [31:0] md(input int i);
        return 32'h5A5A_F00F ^ (32'(i) << 4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one cycle of stimulus, capture the combinational outputs, pass the edge.
    task automatic op(input logic pu, input logic po, input logic ie, input logic ir,
                      input logic [2:0] src, input int idx);
        push_req = pu; pop_req = po; irq_entry = ie; irq_return = ir;
        irq_src = src; status_in = st(idx); mode_in = md(idx);
        #1;
        c_swe = stat_wr_en; c_swd = stat_wr_data; c_mwe = mode_wr_en; c_mwd = mode_wr_data;
        @(negedge clk);
        push_req = 0; pop_req = 0; irq_entry = 0; irq_return = 0;
    endtask

    task automatic t_reset();
        chk("R10 empty", 32'(stk_empty), 1);
        chk("R10 full", 32'(stk_full), 0);
        chk("R10 ovf", 32'(ovf_err), 0);
        chk("R10 unf", 32'(unf_err), 0);
        // mask is zero: a save returns the mode unchanged
        op(1, 0, 0, 0, 0, 1);
        chk("R10 mask zero", c_mwd, md(1));
        op(0, 1, 0, 0, 0, 0);
        chk("R10 pop", c_swd, st(1));
        mmask_we = 1; mmask_wdata = MSK;
        @(negedge clk);
        mmask_we = 0;
    endtask

    task automatic t_push_pop();
        op(1, 0, 0, 0, 0, 7);
        chk("R4 mode_wr_en", 32'(c_mwe), 1);
        chk("R4 cleared mode", c_mwd, md(7) & ~MSK);
        chk("R4 no status load", 32'(c_swe), 0);
        chk("R2 not empty", 32'(stk_empty), 0);
        op(0, 1, 0, 0, 0, 9);
        chk("R1 stat_wr_en", 32'(c_swe), 1);
        chk("R1 status", c_swd, st(7));
        chk("R1 mode_wr_en", 32'(c_mwe), 1);
        chk("R1 mode", c_mwd, md(7));
        chk("R1 empty after", 32'(stk_empty), 1);
    endtask

    task automatic t_irq_sources();
        for (int s = 0; s < 4; s++) begin
            op(0, 0, 1, 0, 3'(s), 20 + s);
            chk("R2 src saves", 32'(c_mwd), md(20 + s) & ~MSK);
            chk("R2 not empty", 32'(stk_empty), 0);
            op(0, 0, 0, 1, 0, 0);
            chk("R5 return restores", c_swd, st(20 + s));
            chk("R5 return en", 32'(c_swe), 1);
        end
        for (int s = 4; s < 8; s++) begin
            op(0, 0, 1, 0, 3'(s), 30 + s);
            chk("R3 no mode write", 32'(c_mwe), 0);
            chk("R3 still empty", 32'(stk_empty), 1);
            op(0, 0, 0, 1, 0, 0);
            chk("R5 no restore", 32'(c_swe), 0);
            chk("R5 no underflow", 32'(unf_err), 0);
        end
    endtask

    task automatic t_nested();
        op(1, 0, 0, 0, 0, 40);
        op(0, 0, 1, 0, 3'd1, 41);
        op(0, 0, 1, 0, 3'd6, 42);
        op(0, 0, 0, 1, 0, 0);
        chk("R5 inner non-saving return", 32'(c_swe), 0);
        op(0, 0, 0, 1, 0, 0);
        chk("R5 outer saving return", c_swd, st(41));
        op(0, 1, 0, 0, 0, 0);
        chk("R6 explicit entry last", c_swd, st(40));
        chk("R6 empty", 32'(stk_empty), 1);
    endtask

    task automatic t_swap_full();
        for (int i = 0; i < 15; i++) op(1, 0, 0, 0, 0, 100 + i);
        chk("R6 full at 15", 32'(stk_full), 1);
        op(1, 1, 0, 0, 0, 99);
        chk("R9 returns top", c_swd, st(114));
        chk("R9 mode restored then cleared", c_mwd, md(114) & ~MSK);
        chk("R9 no overflow", 32'(ovf_err), 0);
        chk("R9 still full", 32'(stk_full), 1);
        op(0, 1, 0, 0, 0, 0);
        chk("R9 new top", c_swd, st(99));
        for (int i = 13; i >= 0; i--) begin
            op(0, 1, 0, 0, 0, 0);
            chk("R6 reverse order", c_swd, st(100 + i));
        end
        chk("R6 empty", 32'(stk_empty), 1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 15; i++) op(1, 0, 0, 0, 0, 200 + i);
        op(1, 0, 0, 0, 0, 77);
        chk("R7 ovf set", 32'(ovf_err), 1);
        chk("R7 full", 32'(stk_full), 1);
        for (int i = 14; i >= 0; i--) begin
            op(0, 1, 0, 0, 0, 0);
            chk("R7 entries intact", c_swd, st(200 + i));
        end
        chk("R7 ovf sticky", 32'(ovf_err), 1);
    endtask

    task automatic t_underflow();
        op(1, 1, 0, 0, 0, 55);
        chk("R9 empty swap no status", 32'(c_swe), 0);
        chk("R9 empty swap mode", c_mwd, md(55) & ~MSK);
        chk("R8 unf set", 32'(unf_err), 1);
        chk("R9 entry stored", 32'(stk_empty), 0);
        op(0, 1, 0, 0, 0, 0);
        chk("R9 stored value", c_swd, st(55));
        op(0, 1, 0, 0, 0, 0);
        chk("R8 no status load", 32'(c_swe), 0);
        chk("R8 no mode load", 32'(c_mwe), 0);
        chk("R8 still empty", 32'(stk_empty), 1);
        chk("R8 unf sticky", 32'(unf_err), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_irq_sources();
        t_nested();
        t_swap_full();
        t_overflow();
        t_underflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule